// File: doc/BRIEF.md
# Set-Associative Address Translation Unit

This unit turns processor virtual addresses into physical addresses. It keeps recent page translations in a small set-associative translation cache. A request that hits the cache is answered in the cycle after it is accepted and makes no memory access. A request that misses makes one read of its page table entry through a memory port. The unit then installs the returned entry and answers.

Every access is checked against the entry's permission bits, on hits and on misses alike. A user-mode access to a supervisor page is refused, and so is a write to a read-only page or an instruction fetch from a page that cannot be executed. An entry whose valid bit is clear produces a page fault and is never installed. A flush input drops all cached translations at once.

The processor offers one request at a time. A new request is taken only when the unit is idle. The response is a one-cycle done pulse with a physical address and a status code.

Top module: `xlat_unit`

## Requirements
- R1: After reset, req_ready is 1, resp_done is 0 and mem_req_valid is 0.
- R2: An access with status 0 (ok) returns a physical address. Its bits 11:0 equal the virtual address bits 11:0, and its upper bits are the page table entry's bits 31:12.
- R3: A request that hits the cache raises resp_done in the cycle right after it is accepted, and makes no memory read.
- R4: A miss makes exactly one memory read, at pt_base plus four times the virtual page number (address bits 31:12). The response follows the read data. The next access to the same page hits.
- R5: If the fetched entry has bit 0 (valid) clear, the status is 1 (page fault) and the address is 0. The entry is not installed, so a repeat access reads memory again.
- R6: The access kinds are 0 read, 1 write and 2 fetch. The status is 2 (protection fault) and the address is 0 in three cases: a user access (req_super=0) to an entry with bit 1 set, a write to an entry with bit 2 clear, or a fetch from an entry with bit 3 clear. This holds on hits as well as misses. A supervisor access to a bit-1 page is allowed, and an entry with valid set is installed even when the access faults.
- R7: The cache has 4 sets of 4 ways, with the set chosen by virtual page number bits 1:0. A fill goes to the lowest invalid way if the set has one. Otherwise it goes to the way named by a per-set pointer that advances on every fill, so the fifth distinct page in a set evicts the first.
- R8: A flush pulse invalidates every cached entry, so the next access to any page misses.
- R9: While a read is pending, mem_req_valid stays high with mem_addr unchanged until mem_req_ready, and req_ready stays low until the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all cached translations |
| pt_base | input | 32 | Page table base byte address |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request accepted this cycle if valid |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 read, 1 write, 2 fetch |
| req_super | input | 1 | 1 supervisor mode, 0 user mode |
| mem_req_valid | output | 1 | Page table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_addr | output | 32 | Entry byte address |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rdata | input | 32 | Page table entry |
| resp_done | output | 1 | One-cycle completion pulse |
| resp_paddr | output | 32 | Physical address, 0 on a fault |
| resp_status | output | 2 | 0 ok, 1 page fault, 2 protection fault |

## Verification
The hardest case to reach from the ports is eviction in a full set once the round-robin pointer has wrapped. It needs four distinct valid pages in one set, plus a refused page that must not take a way. The stimulus first fills set 1 with pages of mixed permissions, including a faulting but valid entry and an invalid entry. It then brings in a fifth page and shows that the oldest page misses while the others still hit. A hit or miss is judged by whether a memory read took place.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic [1:0] {
      ACC_READ  = 2'd0,
      ACC_WRITE = 2'd1,
      ACC_FETCH = 2'd2
   } acc_e;

   typedef enum logic [1:0] {
      ST_OK   = 2'd0,
      ST_PGF  = 2'd1,
      ST_PROT = 2'd2
   } stat_e;

   typedef struct packed {
      logic exec;
      logic wr;
      logic sup;
   } perm_t;

   localparam int PTE_V_BIT = 0;
   localparam int PTE_S_BIT = 1;
   localparam int PTE_W_BIT = 2;
   localparam int PTE_X_BIT = 3;

endpackage

// File: rtl/xlat_victim_sel.sv
module xlat_victim_sel #(
   parameter int WAYS          = 4,
   parameter bit INVALID_FIRST = 1'b1,
   localparam int WAY_W        = $clog2(WAYS)
) (
   input  logic [WAYS-1:0]  valid,
   input  logic [WAY_W-1:0] ptr,
   output logic [WAY_W-1:0] way
);

   generate
      if (INVALID_FIRST) begin : g_free_first
         always_comb begin
            way = ptr;
            for (int w = WAYS - 1; w >= 0; w--) begin
               if (!valid[w]) way = WAY_W'(w);
            end
         end
      end else begin : g_rr_only
         logic unused_valid;
         assign unused_valid = ^valid;
         assign way = ptr;
      end
   endgenerate

endmodule

// File: rtl/xlat_perm_check.sv
module xlat_perm_check
   import xlat_pkg::*;
(
   input  perm_t      perm,
   input  logic [1:0] kind,
   input  logic       super_mode,
   output logic       deny
);

   logic user_hit_sup;
   logic bad_write;
   logic bad_fetch;

   assign user_hit_sup = perm.sup && !super_mode;
   assign bad_write    = (kind == ACC_WRITE) && !perm.wr;
   assign bad_fetch    = (kind == ACC_FETCH) && !perm.exec;
   assign deny         = user_hit_sup || bad_write || bad_fetch;

endmodule

// File: rtl/xlat_tag_store.sv
module xlat_tag_store
   import xlat_pkg::*;
#(
   parameter int VPN_W  = 20,
   parameter int PPN_W  = 20,
   parameter int SETS   = 4,
   parameter int WAYS   = 4,
   localparam int IDX_W = $clog2(SETS),
   localparam int TAG_W = VPN_W - IDX_W,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic [VPN_W-1:0] lk_vpn,
   output logic             lk_hit,
   output logic [PPN_W-1:0] lk_ppn,
   output perm_t            lk_perm,
   input  logic             fill_en,
   input  logic [VPN_W-1:0] fill_vpn,
   input  logic [PPN_W-1:0] fill_ppn,
   input  perm_t            fill_perm
);

   logic [WAYS-1:0]  vld_q  [SETS];
   logic [WAY_W-1:0] ptr_q  [SETS];
   logic [TAG_W-1:0] tag_q  [SETS][WAYS];
   logic [PPN_W-1:0] ppn_q  [SETS][WAYS];
   perm_t            perm_q [SETS][WAYS];

   logic [IDX_W-1:0] lk_idx;
   logic [TAG_W-1:0] lk_tag;
   logic [IDX_W-1:0] fi_idx;
   logic [TAG_W-1:0] fi_tag;
   logic [WAYS-1:0]  hit_vec;
   logic [WAY_W-1:0] vic_way;

   assign lk_idx = lk_vpn[IDX_W-1:0];
   assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
   assign fi_idx = fill_vpn[IDX_W-1:0];
   assign fi_tag = fill_vpn[VPN_W-1:IDX_W];

   genvar gw;
   generate
      for (gw = 0; gw < WAYS; gw++) begin : g_cmp
         assign hit_vec[gw] = vld_q[lk_idx][gw] && (tag_q[lk_idx][gw] == lk_tag);
      end
   endgenerate

   assign lk_hit = |hit_vec;

   always_comb begin
      lk_ppn  = '0;
      lk_perm = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) begin
            lk_ppn  = lk_ppn | ppn_q[lk_idx][w];
            lk_perm = lk_perm | perm_q[lk_idx][w];
         end
      end
   end

   xlat_victim_sel #(.WAYS(WAYS), .INVALID_FIRST(1'b1)) u_victim (
      .valid (vld_q[fi_idx]),
      .ptr   (ptr_q[fi_idx]),
      .way   (vic_way)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s] <= '0;
            ptr_q[s] <= '0;
         end
      end else if (flush) begin
         for (int s = 0; s < SETS; s++) vld_q[s] <= '0;
      end else if (fill_en) begin
         vld_q[fi_idx][vic_way] <= 1'b1;
         ptr_q[fi_idx]          <= ptr_q[fi_idx] + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[fi_idx][vic_way]  <= fi_tag;
         ppn_q[fi_idx][vic_way]  <= fill_ppn;
         perm_q[fi_idx][vic_way] <= fill_perm;
      end
   end

endmodule

// File: rtl/xlat_unit.sv
module xlat_unit
   import xlat_pkg::*;
#(
   parameter int VA_W  = 32,
   parameter int PA_W  = 32,
   parameter int OFF_W = 12,
   parameter int PTE_W = 32,
   parameter int SETS  = 4,
   parameter int WAYS  = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic [PA_W-1:0] pt_base,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic [VA_W-1:0] req_vaddr,
   input  logic [1:0]      req_kind,
   input  logic            req_super,
   output logic            mem_req_valid,
   input  logic            mem_req_ready,
   output logic [PA_W-1:0] mem_addr,
   input  logic            mem_rsp_valid,
   input  logic [PTE_W-1:0] mem_rdata,
   output logic            resp_done,
   output logic [PA_W-1:0] resp_paddr,
   output logic [1:0]      resp_status
);

   localparam int VPN_W  = VA_W - OFF_W;
   localparam int PPN_W  = PA_W - OFF_W;
   localparam int PTE_SH = $clog2(PTE_W / 8);

   generate
      if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
         $error("WAYS must be a power of two of at least 2");
      end
      if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
         $error("SETS must be a power of two of at least 2");
      end
      if (PPN_W > PTE_W - OFF_W) begin : g_bad_pte
         $error("physical page number does not fit the entry");
      end
      if (PA_W < VPN_W + PTE_SH) begin : g_bad_walk
         $error("entry address too narrow for the page number");
      end
   endgenerate

   typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_e;

   state_e          state_q;
   logic [VA_W-1:0] vaddr_q;
   logic [1:0]      kind_q;
   logic            super_q;
   logic [PA_W-1:0] mem_addr_q;
   logic            resp_done_q;
   logic [PA_W-1:0] resp_paddr_q;
   logic [1:0]      resp_status_q;

   logic [VPN_W-1:0] lk_vpn;
   logic             lk_hit;
   logic [PPN_W-1:0] lk_ppn;
   perm_t            lk_perm;
   logic [PA_W-1:0]  walk_addr;

   perm_t            pte_perm;
   logic [PPN_W-1:0] pte_ppn;
   logic             pte_valid;
   logic             fill_en;

   perm_t            chk_perm;
   logic [1:0]       chk_kind;
   logic             chk_super;
   logic             deny;

   logic             unused_pte_bits;

   assign lk_vpn    = req_vaddr[VA_W-1:OFF_W];
   assign walk_addr = pt_base + (PA_W'(lk_vpn) << PTE_SH);

   assign pte_valid     = mem_rdata[PTE_V_BIT];
   assign pte_perm.sup  = mem_rdata[PTE_S_BIT];
   assign pte_perm.wr   = mem_rdata[PTE_W_BIT];
   assign pte_perm.exec = mem_rdata[PTE_X_BIT];
   assign pte_ppn       = mem_rdata[PTE_W-1 -: PPN_W];
   assign unused_pte_bits = ^mem_rdata[PTE_W-PPN_W-1:PTE_X_BIT+1];

   assign fill_en = (state_q == S_WAIT) && mem_rsp_valid && pte_valid && !flush;

   xlat_tag_store #(
      .VPN_W (VPN_W),
      .PPN_W (PPN_W),
      .SETS  (SETS),
      .WAYS  (WAYS)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .flush     (flush),
      .lk_vpn    (lk_vpn),
      .lk_hit    (lk_hit),
      .lk_ppn    (lk_ppn),
      .lk_perm   (lk_perm),
      .fill_en   (fill_en),
      .fill_vpn  (vaddr_q[VA_W-1:OFF_W]),
      .fill_ppn  (pte_ppn),
      .fill_perm (pte_perm)
   );

   always_comb begin
      if (state_q == S_IDLE) begin
         chk_perm  = lk_perm;
         chk_kind  = req_kind;
         chk_super = req_super;
      end else begin
         chk_perm  = pte_perm;
         chk_kind  = kind_q;
         chk_super = super_q;
      end
   end

   xlat_perm_check u_perm (
      .perm       (chk_perm),
      .kind       (chk_kind),
      .super_mode (chk_super),
      .deny       (deny)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q       <= S_IDLE;
         vaddr_q       <= '0;
         kind_q        <= ACC_READ;
         super_q       <= 1'b0;
         mem_addr_q    <= '0;
         resp_done_q   <= 1'b0;
         resp_paddr_q  <= '0;
         resp_status_q <= ST_OK;
      end else begin
         resp_done_q <= 1'b0;
         case (state_q)
            S_IDLE: begin
               if (req_valid) begin
                  vaddr_q <= req_vaddr;
                  kind_q  <= req_kind;
                  super_q <= req_super;
                  if (lk_hit) begin
                     resp_done_q <= 1'b1;
                     if (deny) begin
                        resp_status_q <= ST_PROT;
                        resp_paddr_q  <= '0;
                     end else begin
                        resp_status_q <= ST_OK;
                        resp_paddr_q  <= {lk_ppn, req_vaddr[OFF_W-1:0]};
                     end
                  end else begin
                     mem_addr_q <= walk_addr;
                     state_q    <= S_REQ;
                  end
               end
            end
            S_REQ: begin
               if (mem_req_ready) state_q <= S_WAIT;
            end
            S_WAIT: begin
               if (mem_rsp_valid) begin
                  resp_done_q <= 1'b1;
                  state_q     <= S_IDLE;
                  if (!pte_valid) begin
                     resp_status_q <= ST_PGF;
                     resp_paddr_q  <= '0;
                  end else if (deny) begin
                     resp_status_q <= ST_PROT;
                     resp_paddr_q  <= '0;
                  end else begin
                     resp_status_q <= ST_OK;
                     resp_paddr_q  <= {pte_ppn, vaddr_q[OFF_W-1:0]};
                  end
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assign req_ready     = (state_q == S_IDLE);
   assign mem_req_valid = (state_q == S_REQ);
   assign mem_addr      = mem_addr_q;
   assign resp_done     = resp_done_q;
   assign resp_paddr    = resp_paddr_q;
   assign resp_status   = resp_status_q;

endmodule

// File: rtl/xlat_unit_chk.sv
module xlat_unit_chk #(
   parameter int VA_W  = 32,
   parameter int PA_W  = 32,
   parameter int OFF_W = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_valid,
   input logic            req_ready,
   input logic            lk_hit,
   input logic [VA_W-1:0] vaddr_q,
   input logic            mem_req_valid,
   input logic            mem_req_ready,
   input logic [PA_W-1:0] mem_addr,
   input logic            resp_done,
   input logic [PA_W-1:0] resp_paddr,
   input logic [1:0]      resp_status
);

   // R9
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr));

   // R9
   busy_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   // R4
   single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid && mem_req_ready |=> !mem_req_valid);

   // R3
   hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && lk_hit |=> resp_done && !mem_req_valid);

   // R2
   offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_done && resp_status == 2'd0 |-> resp_paddr[OFF_W-1:0] == vaddr_q[OFF_W-1:0]);

   // R5
   fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_done && resp_status != 2'd0 |-> resp_paddr == '0);

   // R6
   status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resp_done |-> resp_status != 2'd3);

endmodule

bind xlat_unit xlat_unit_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .req_valid     (req_valid),
   .req_ready     (req_ready),
   .lk_hit        (lk_hit),
   .vaddr_q       (vaddr_q),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_addr      (mem_addr),
   .resp_done     (resp_done),
   .resp_paddr    (resp_paddr),
   .resp_status   (resp_status)
);

// File: tb/xlat_unit_test.sv
`timescale 1ns/1ps
module xlat_unit_test;

   localparam logic [31:0] BASE = 32'h0010_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic [31:0] pt_base = BASE;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_vaddr = '0;
   logic [1:0]  req_kind = '0;
   logic        req_super = 1'b0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [31:0] mem_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        resp_done;
   logic [31:0] resp_paddr;
   logic [1:0]  resp_status;

   always #4 clk = ~clk;

   xlat_unit uut (
      .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base(pt_base),
      .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
      .req_kind(req_kind), .req_super(req_super),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_addr(mem_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata),
      .resp_done(resp_done), .resp_paddr(resp_paddr), .resp_status(resp_status)
   );

   typedef struct {
      logic [31:0] paddr;
      logic [1:0]  st;
      int          reads;
      logic [31:0] maddr;
      int          acc;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   int          n_chk = 0;
   int          n_bad = 0;
   int          cyc = 0;
   int          reads = 0;
   logic [31:0] last_maddr = '0;
   bit          finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Page table contents: valid unless vpn bit9, supervisor on bit8,
   // read-only on bit7, executable on bit6, ppn = vpn + 0x30000.
   function automatic logic [31:0] pte_of(input logic [19:0] vpn);
      logic [19:0] ppn;
      ppn = vpn + 20'h30000;
      return {ppn, 8'h00, vpn[6], ~vpn[7], vpn[8], ~vpn[9]};
   endfunction

   // memory model
   initial begin
      int dly = 0;
      forever begin
         @(negedge clk);
         if (mem_req_valid) begin
            logic [31:0] first_addr;
            first_addr = mem_addr;
            repeat (dly) @(negedge clk);
            chk("R9 addr held", mem_addr, first_addr);
            chk("R9 req_ready low", {31'd0, req_ready}, 32'd0);
            mem_req_ready = 1'b1;
            last_maddr = mem_addr;
            reads++;
            @(negedge clk);
            mem_req_ready = 1'b0;
            repeat (2) @(negedge clk);
            mem_rsp_valid = 1'b1;
            mem_rdata = pte_of(20'((last_maddr - BASE) >> 2));
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            dly = (dly == 0) ? 2 : 0;
         end
      end
   end

   // monitor
   initial begin
      forever begin
         @(negedge clk);
         if (resp_done) begin
            if (sb.size() == 0) begin
               chk("unexpected response", 32'd1, 32'd0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk({e.tag, " status"}, {30'd0, resp_status}, {30'd0, e.st});
               chk({e.tag, " paddr"}, resp_paddr, e.paddr);
               chk({e.tag, " reads"}, reads, e.reads);
               if (e.reads == 0)
                  chk({e.tag, " R3 hit latency"}, cyc, e.acc);
               else
                  chk({e.tag, " R4 entry address"}, last_maddr, e.maddr);
            end
            reads = 0;
         end
      end
   end

   task automatic issue(input logic [19:0] vpn, input logic [11:0] off,
                        input logic [1:0] kind, input logic sup,
                        input int rd, input string tag);
      exp_t e;
      logic [31:0] p;
      p = pte_of(vpn);
      if (!p[0])                                   e.st = 2'd1;
      else if ((p[1] && !sup) || (kind == 2'd1 && !p[2]) || (kind == 2'd2 && !p[3]))
                                                   e.st = 2'd2;
      else                                         e.st = 2'd0;
      e.paddr = (e.st == 2'd0) ? {p[31:12], off} : 32'd0;
      e.reads = rd;
      e.maddr = BASE + {10'd0, vpn, 2'b00};
      e.tag   = tag;
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = {vpn, off};
      req_kind  = kind;
      req_super = sup;
      e.acc     = cyc + 1;
      sb.push_back(e);
      @(negedge clk);
      req_valid = 1'b0;
      while (sb.size() != 0) @(negedge clk);
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
      chk("R1 resp_done", {31'd0, resp_done}, 32'd0);
      chk("R1 mem_req_valid", {31'd0, mem_req_valid}, 32'd0);

      issue(20'h00001, 12'h234, 2'd0, 1'b0, 1, "R4 R2 first read");
      issue(20'h00001, 12'hABC, 2'd0, 1'b0, 0, "R3 read hit");
      issue(20'h00001, 12'h010, 2'd1, 1'b0, 0, "R3 write hit");
      issue(20'h00001, 12'h020, 2'd2, 1'b0, 0, "R6 fetch no-exec hit");
      issue(20'h00041, 12'h100, 2'd2, 1'b0, 1, "R6 fetch exec miss");
      issue(20'h00081, 12'h200, 2'd1, 1'b0, 1, "R6 write read-only miss");
      issue(20'h00081, 12'h204, 2'd0, 1'b0, 0, "R4 R6 faulted entry installed");
      issue(20'h00101, 12'h300, 2'd0, 1'b0, 1, "R6 user to supervisor");
      issue(20'h00101, 12'h304, 2'd0, 1'b1, 0, "R6 supervisor hit");
      issue(20'h00201, 12'h400, 2'd0, 1'b1, 1, "R5 invalid entry");
      issue(20'h00201, 12'h404, 2'd0, 1'b1, 1, "R5 not installed");
      issue(20'h00002, 12'h555, 2'd1, 1'b0, 1, "R2 other set");
      issue(20'h00002, 12'h556, 2'd0, 1'b0, 0, "R3 other set hit");
      issue(20'h00005, 12'h600, 2'd0, 1'b0, 1, "R7 fifth page");
      issue(20'h00041, 12'h604, 2'd2, 1'b0, 0, "R7 second page kept");
      issue(20'h00001, 12'h608, 2'd0, 1'b0, 1, "R7 oldest evicted");
      issue(20'h00081, 12'h60C, 2'd0, 1'b0, 0, "R7 third page kept");
      issue(20'h00041, 12'h610, 2'd0, 1'b0, 1, "R7 pointer order");
      do_flush();
      issue(20'h00002, 12'h700, 2'd0, 1'b0, 1, "R8 miss after flush");
      issue(20'h00101, 12'h704, 2'd0, 1'b1, 1, "R8 second miss after flush");
      issue(20'h00101, 12'h708, 2'd2, 1'b1, 0, "R6 supervisor fetch no-exec");

      repeat (4) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         summary();
         $finish;
      end
   end

endmodule